// File: doc/BRIEF.md
# PCI configuration address translator

This block sits between a CPU-side decode of a south-bridge configuration window and the logic that runs PCI configuration cycles. For each request it joins the 16-bit byte offset within the window with the low half of a 32-bit mapping register. The result is a 32-bit intermediate address. From that address it pulls a one-hot device select field, a function number and a register offset, and it packs them with a static bus number into a type-0 configuration address. Bit 31 of that address is the enable bit.

The translation itself is combinational. The results are registered on a request handshake, so every request produces one result cycle. A request can be rejected for three reasons: the mapping register marks the window as unsupported, the size code is not legal, or the device select field is empty. A rejected request is not forwarded. A rejected read returns all-ones data sized to the access width. Each accepted request, read or write, pulses a request to clear the received-master-abort and received-target-abort status bits. Accesses that are not word aligned are flagged and still forwarded.

Top module: `cfgx_translator`

## Requirements
- R1: After reset `out_valid`, `cfg_go` and `clr_abort` are low and `cfg_addr` and `rd_data` are zero.
- R2: A request sampled with `req_valid` high at a rising edge gives `out_valid` high for exactly the following cycle. With no request, `out_valid`, `cfg_go` and `clr_abort` stay low.
- R3: The intermediate address is `{map_reg[15:0], req_addr[15:0]}`. Its bits [10:8] are the function number and its bits [7:0] are the register offset.
- R4: The device number is the index, counted from bit 11, of the lowest set bit among bits [31:11] of the intermediate address. Intermediate bit 17 gives device 6, and bit 31 alone gives device 20.
- R5: An accepted request drives `cfg_go` high and sets `cfg_addr` as follows: bit 31 = 1, [30:24] = 0, [23:16] = `bus_num`, [15:11] = device, [10:8] = function, [7:0] = register. A rejected request drives `cfg_go` low and `cfg_addr` to zero. `cfg_write` and `cfg_size` echo the request.
- R6: When `map_reg[16]` is 1, `unsup` and `rejected` are set and the request is not forwarded. A read then returns all ones sized by `req_size`: code 0 (1 byte) gives 0x000000FF, code 1 (2 bytes) gives 0x0000FFFF and code 2 (4 bytes) gives 0xFFFFFFFF. A rejected write returns zero data.
- R7: When `map_reg[16]` is 0 and bits [31:11] of the intermediate address are all zero, `idsel_err` and `rejected` are set. A read then returns the sized all-ones value of R6.
- R8: `clr_abort` pulses for one cycle, together with `out_valid`, for every accepted request, read or write. It stays low for rejected requests.
- R9: Size code 3 is illegal. Such a request is rejected without setting `unsup` or `idsel_err`, and a read returns 0xFFFFFFFF.
- R10: `subword` is set when `req_addr[1:0]` is nonzero. It does not affect acceptance. An accepted read returns zero data, because its data comes from the bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = illegal |
| req_addr | input | 16 | Byte offset within the configuration window |
| map_reg | input | 32 | Mapping register; [15:0] upper address half, [16] unsupported |
| bus_num | input | 8 | Static bus number |
| out_valid | output | 1 | Result cycle for the previous request |
| cfg_go | output | 1 | Request accepted and forwarded |
| cfg_addr | output | 32 | Type-0 configuration address with enable in bit 31 |
| cfg_write | output | 1 | Echo of request direction |
| cfg_size | output | 2 | Echo of request size code |
| rd_data | output | 32 | All-ones fill for rejected reads, zero otherwise |
| rejected | output | 1 | Request not forwarded |
| unsup | output | 1 | Mapping register marked the window unsupported |
| idsel_err | output | 1 | Device select field empty |
| subword | output | 1 | Address not word aligned |
| clr_abort | output | 1 | Pulse requesting clear of both received-abort status bits |

## Verification
All decode results pass through a single result register. A fault in that register or in the decode therefore appears at the ports in the cycle right after the request. A priority encoder that picks the wrong set bit shows up as a wrong device field in `cfg_addr[15:11]`. A reject condition combined wrongly shows up as `cfg_go` or `clr_abort` disagreeing with the flags, or as all-ones data of the wrong width. Pulses that are not cleared would leave `out_valid` or `clr_abort` high in the idle cycle after a request. One-hot selects at every position, empty selects, both reject sources, the illegal size and unaligned offsets are each driven and checked on that following cycle.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    localparam int CFG_W     = 32;
    localparam int WIN_W     = 16;
    localparam int MAP_LO_W  = CFG_W - WIN_W;
    localparam int IDSEL_LSB = 11;
    localparam int IDSEL_W   = CFG_W - IDSEL_LSB;
    localparam int DEV_W     = $clog2(IDSEL_W);
    localparam int FN_LSB    = 8;
    localparam int FN_W      = 3;
    localparam int REG_W     = 8;
    localparam int BUS_W     = 8;
    localparam int BUS_LSB   = 16;
    localparam int UNSUP_BIT = 16;
    localparam int LANES     = CFG_W / 8;
    localparam int PAD_W     = CFG_W - 1 - BUS_LSB - BUS_W;

    typedef enum logic [1:0] {
        SZ_B1  = 2'd0,
        SZ_B2  = 2'd1,
        SZ_B4  = 2'd2,
        SZ_BAD = 2'd3
    } size_e;

    typedef struct packed {
        logic             valid;
        logic             go;
        logic [CFG_W-1:0] addr;
        logic             write;
        logic [1:0]       size;
        logic [CFG_W-1:0] rdata;
        logic             rejected;
        logic             unsup;
        logic             idsel_err;
        logic             subword;
        logic             clr;
    } result_s;
endpackage

// File: rtl/cfgx_ctz.sv
module cfgx_ctz #(
    parameter int W  = 21,
    parameter int OW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [OW-1:0] idx,
    output logic          none
);
    logic [W:0]   clear_below;
    logic [W-1:0] first;

    assign clear_below[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_chain
        assign clear_below[i+1] = clear_below[i] & ~vec[i];
        assign first[i]         = vec[i] & clear_below[i];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (first[i]) idx = idx | OW'(i);
        end
    end

    assign none = clear_below[W];
endmodule

// File: rtl/cfgx_fill.sv
module cfgx_fill
    import cfgx_pkg::*;
(
    input  logic [1:0]       size,
    output logic [CFG_W-1:0] mask
);
    size_e sz;
    assign sz = size_e'(size);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic lane_on;
        always_comb begin
            unique case (sz)
                SZ_B1:   lane_on = (k == 0);
                SZ_B2:   lane_on = (k < 2);
                default: lane_on = 1'b1;
            endcase
        end
        assign mask[8*k +: 8] = {8{lane_on}};
    end
endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
    import cfgx_pkg::*;
(
    input  logic             write,
    input  logic [1:0]       size,
    input  logic [WIN_W-1:0] win_addr,
    input  logic [CFG_W-1:0] map,
    input  logic [BUS_W-1:0] bus,
    output result_s          res
);
    logic [CFG_W-1:0]   mid_addr;
    logic [IDSEL_W-1:0] sel_field;
    logic [DEV_W-1:0]   dev_num;
    logic               sel_empty;
    logic [CFG_W-1:0]   ones_fill;
    logic               size_bad;
    logic               is_unsup;
    logic               reject;
    logic [CFG_W-1:0]   unused_map;

    assign mid_addr   = {map[MAP_LO_W-1:0], win_addr};
    assign sel_field  = mid_addr[CFG_W-1:IDSEL_LSB];
    assign unused_map = map;

    cfgx_ctz #(.W(IDSEL_W), .OW(DEV_W)) u_ctz (
        .vec  (sel_field),
        .idx  (dev_num),
        .none (sel_empty)
    );

    cfgx_fill u_fill (
        .size (size),
        .mask (ones_fill)
    );

    assign is_unsup = map[UNSUP_BIT];
    assign size_bad = (size_e'(size) == SZ_BAD);
    assign reject   = is_unsup | size_bad | sel_empty;

    always_comb begin
        res           = '0;
        res.write     = write;
        res.size      = size;
        res.unsup     = is_unsup;
        res.idsel_err = ~is_unsup & sel_empty;
        res.rejected  = reject;
        res.subword   = |win_addr[1:0];
        res.go        = ~reject;
        res.clr       = ~reject;
        if (!reject) begin
            res.addr = {1'b1, {PAD_W{1'b0}}, bus, dev_num,
                        mid_addr[FN_LSB +: FN_W], mid_addr[REG_W-1:0]};
        end
        if (reject && !write) begin
            res.rdata = ones_fill;
        end
    end
endmodule

// File: rtl/cfgx_translator.sv
module cfgx_translator
    import cfgx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_size,
    input  logic [WIN_W-1:0]     req_addr,
    input  logic [CFG_W-1:0]     map_reg,
    input  logic [BUS_W-1:0]     bus_num,
    output logic                 out_valid,
    output logic                 cfg_go,
    output logic [CFG_W-1:0]     cfg_addr,
    output logic                 cfg_write,
    output logic [1:0]           cfg_size,
    output logic [CFG_W-1:0]     rd_data,
    output logic                 rejected,
    output logic                 unsup,
    output logic                 idsel_err,
    output logic                 subword,
    output logic                 clr_abort
);
    result_s dec;
    result_s st_d, st_q;

    cfgx_decode u_dec (
        .write    (req_write),
        .size     (req_size),
        .win_addr (req_addr),
        .map      (map_reg),
        .bus      (bus_num),
        .res      (dec)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.go    = 1'b0;
        st_d.clr   = 1'b0;
        if (req_valid) begin
            st_d       = dec;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign cfg_go    = st_q.go;
    assign cfg_addr  = st_q.addr;
    assign cfg_write = st_q.write;
    assign cfg_size  = st_q.size;
    assign rd_data   = st_q.rdata;
    assign rejected  = st_q.rejected;
    assign unsup     = st_q.unsup;
    assign idsel_err = st_q.idsel_err;
    assign subword   = st_q.subword;
    assign clr_abort = st_q.clr;

    assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid && !cfg_go && !clr_abort);

    assert_go_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_go |-> cfg_addr[CFG_W-1] && cfg_addr[CFG_W-2 -: PAD_W] == '0);

    assert_dev_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_go |-> int'(cfg_addr[IDSEL_LSB +: DEV_W]) < IDSEL_W);

    assert_unsup_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        unsup |-> !cfg_go && !clr_abort && rejected);

    assert_clear_accepted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_abort |-> out_valid && !unsup && !idsel_err);

    assert_empty_sel_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && idsel_err && !cfg_write |-> rd_data[7:0] == 8'hFF);
endmodule

// File: tb/tb_cfgx_translator.sv
`timescale 1ns/1ps
module tb_cfgx_translator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [15:0] req_addr = '0;
    logic [31:0] map_reg = '0;
    logic [7:0]  bus_num = 8'h3C;
    logic        out_valid, cfg_go, cfg_write, rejected, unsup, idsel_err, subword, clr_abort;
    logic [31:0] cfg_addr, rd_data;
    logic [1:0]  cfg_size;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfgx_translator dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .map_reg(map_reg), .bus_num(bus_num),
        .out_valid(out_valid), .cfg_go(cfg_go), .cfg_addr(cfg_addr), .cfg_write(cfg_write),
        .cfg_size(cfg_size), .rd_data(rd_data), .rejected(rejected), .unsup(unsup),
        .idsel_err(idsel_err), .subword(subword), .clr_abort(clr_abort)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] fill(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic int low_one(input logic [20:0] v);
        for (int i = 0; i < 21; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic send(input logic w, input logic [1:0] sz, input logic [15:0] a, input logic [31:0] m);
        logic [31:0] mid, e_addr, e_rd;
        logic [20:0] sel;
        logic e_uns, e_bad, e_empty, e_rej;
        int dev;
        req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; map_reg = m;
        mid     = {m[15:0], a};
        sel     = mid[31:11];
        dev     = low_one(sel);
        e_uns   = m[16];
        e_bad   = (sz == 2'd3);
        e_empty = (sel == '0);
        e_rej   = e_uns | e_bad | e_empty;
        e_addr  = e_rej ? 32'h0 : {1'b1, 7'h0, bus_num, 5'(dev), mid[10:8], mid[7:0]};
        e_rd    = (e_rej && !w) ? fill(sz) : 32'h0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "out_valid", {31'h0, out_valid}, 32'h1);
        chk("R5", "cfg_addr", cfg_addr, e_addr);
        chk("R4", "device", {27'h0, cfg_addr[15:11]}, e_rej ? 32'h0 : 32'(dev));
        chk("R3", "fn_reg", {21'h0, cfg_addr[10:0]}, e_rej ? 32'h0 : {21'h0, mid[10:0]});
        chk("R5", "go", {31'h0, cfg_go}, {31'h0, ~e_rej});
        chk("R5", "echo", {29'h0, cfg_write, cfg_size}, {29'h0, w, sz});
        chk("R6", "rd_data", rd_data, e_rd);
        chk("R6", "unsup", {31'h0, unsup}, {31'h0, e_uns});
        chk("R7", "idsel_err", {31'h0, idsel_err}, {31'h0, ~e_uns & e_empty});
        chk("R9", "rejected", {31'h0, rejected}, {31'h0, e_rej});
        chk("R10", "subword", {31'h0, subword}, {31'h0, |a[1:0]});
        chk("R8", "clr_abort", {31'h0, clr_abort}, {31'h0, ~e_rej});
    endtask

    task automatic idle_check();
        @(negedge clk);
        chk("R2", "idle pulses", {29'h0, out_valid, cfg_go, clr_abort}, 32'h0);
    endtask

    task automatic send_onehot(input logic w, input logic [1:0] sz, input int pos, input logic [10:0] low);
        logic [31:0] mid;
        mid = (32'h1 << (pos + 11)) | {21'h0, low};
        send(w, sz, mid[15:0], {16'h0, mid[31:16]});
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk("R1", "reset pulses", {29'h0, out_valid, cfg_go, clr_abort}, 32'h0);
        chk("R1", "reset addr", cfg_addr, 32'h0);
        chk("R1", "reset rd", rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "after reset idle", {31'h0, out_valid}, 32'h0);

        // R4 directed: intermediate bit 17 gives device 6; bit 31 alone gives 20
        send_onehot(1'b0, 2'd2, 6, 11'h2A4);
        send_onehot(1'b1, 2'd0, 20, 11'h7FF);
        send_onehot(1'b0, 2'd1, 0, 11'h013);
        idle_check();
        // R6 unsupported window, each size
        send(1'b0, 2'd0, 16'h8000, 32'h0001_0002);
        send(1'b0, 2'd1, 16'h8000, 32'h0001_0002);
        send(1'b0, 2'd2, 16'h8000, 32'h0001_0002);
        send(1'b1, 2'd2, 16'h8000, 32'h0001_0002);
        // R7 empty select
        send(1'b0, 2'd1, 16'h07FC, 32'h0000_0000);
        send(1'b1, 2'd0, 16'h0001, 32'h0000_0000);
        // R9 illegal size
        send(1'b0, 2'd3, 16'h4000, 32'h0000_0000);
        // R10 unaligned accepted
        send(1'b0, 2'd0, 16'h0803, 32'h0000_0000);
        idle_check();
        bus_num = 8'hA5;

        for (int n = 0; n < 400; n++) begin
            logic [31:0] m;
            logic [15:0] a;
            int kind;
            kind = $urandom % 4;
            m = $urandom;
            a = 16'($urandom);
            if (kind == 0) begin
                m[15:0] = 16'h0; a[15:11] = 5'h0;
            end
            if (($urandom % 3) != 0) m[16] = 1'b0;
            if (kind == 1) begin
                send_onehot(1'($urandom), 2'($urandom), $urandom % 21, 11'($urandom));
            end else begin
                send(1'($urandom), 2'($urandom), a, m);
            end
            if (($urandom % 8) == 0) idle_check();
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule